// File: doc/BRIEF.md
# PCI Target CSR Access Unit

This block sits on a 32-bit PCI bus as a target and lets a host reach a small bank of 32-bit control and status registers. The bank appears twice in the host's address map: once in a 4 KB memory window and once in a 64-byte I/O window. Each window is placed by its own static base value. Both windows land on the same registers, so a value written through one window reads back through the other.

Every claimed transaction is served with medium decode timing and no target wait states. Exactly one data phase is completed, and STOP# is asserted together with TRDY#, so any attempt at a burst ends as a disconnect with data. The initiator may stall by holding IRDY# high. The target then keeps its handshake and its read data steady until IRDY# is asserted. The tri-state bus is split into separate input, output and output-enable ports. The register bank lives inside the block and is reset to zero.

Top module: `pci_csr_target`

## Requirements
- R1: The address is sampled on the first rising edge at which FRAME# is low after having been high. A claim is made only for a memory read or write command (C/BE# 4'b0110 / 4'b0111) whose AD[31:12] equals `mem_base`, or an I/O read or write command (4'b0010 / 4'b0011) whose AD[31:6] equals `io_base`. On a claim, DEVSEL# is high in the clock after the address edge and low from the second clock after it.
- R2: A transaction that does not match R1 never asserts DEVSEL#, TRDY# or STOP#, keeps `ctl_oe` and `ad_oe` low, and does not change any register.
- R3: TRDY# goes low in the same clock as DEVSEL#, so there are no target wait states.
- R4: STOP# is low whenever TRDY# is low. After one data transfer, TRDY# stays high for the rest of the transaction, even if FRAME# is still low.
- R5: While TRDY# is low and IRDY# is high, TRDY#, STOP#, DEVSEL# and `ad_out` keep their values until the clock in which IRDY# is low.
- R6: On a read, `ad_oe` is low in the turnaround clock after the address phase, is high with the register value during the data phase, and is low again in the clock after the transfer.
- R7: On a write, byte i of the addressed register (bits 8i+7 to 8i) takes AD byte i only if C/BE#[i] is low in the transfer clock. All other bytes keep their value.
- R8: The register offset is AD[11:2] in the memory window and AD[5:2] in the I/O window, and both windows address the same bank. Offsets at or above NREGS read as zero and ignore writes; in particular, they do not alias onto lower registers.
- R9: Once FRAME# and IRDY# are both sampled high after the transfer, the target drives DEVSEL# and STOP# high for one clock and then drops `ctl_oe`.
- R10: After reset, all registers are zero, `ctl_oe` and `ad_oe` are low, and DEVSEL#, TRDY# and STOP# are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME#, driven by the initiator |
| irdy_n | input | 1 | IRDY#, driven by the initiator |
| ad_in | input | 32 | AD bus as seen by the target |
| cbe_n | input | 4 | C/BE# bus: command, then byte enables |
| mem_base | input | 32-MEM_WIN_BITS | Static base of the memory window |
| io_base | input | 32-IO_WIN_BITS | Static base of the I/O window |
| ad_out | output | 32 | Read data for the AD bus |
| ad_oe | output | 1 | Enables the AD drivers |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| devsel_n | output | 1 | DEVSEL# value |
| ctl_oe | output | 1 | Enables the TRDY#, STOP# and DEVSEL# drivers |

## Verification
A fault in the sequencer shows at the ports within one or two clocks of the address edge. Examples are a claim in the wrong clock, a TRDY# without STOP#, or a second TRDY# pulse on a burst. A fault in the stall path shows as read data or handshake changing while IRDY# is held high.

Faults in the decode or the bank are latent until a later read. Examples are a lost byte enable, an offset that aliases, or a miss that still writes. The sweeps therefore write every offset through one window and read it back through the other, including offsets past the bank and offsets that would alias if the range check were lost.

// File: rtl/pci_csr_pkg.sv
`timescale 1ns/1ps
package pci_csr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_HOLD,
    ST_TURN,
    ST_BUSY
  } tgt_state_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pci_csr_decode.sv
`timescale 1ns/1ps
module pci_csr_decode
  import pci_csr_pkg::*;
#(
  parameter int MEM_WIN_BITS = 12,
  parameter int IO_WIN_BITS  = 6,
  parameter int NREGS        = 8,
  parameter int IDX_W        = $clog2(NREGS)
) (
  input  logic [31:0]              addr,
  input  logic [3:0]               cmd,
  input  logic [31-MEM_WIN_BITS:0] mem_base,
  input  logic [31-IO_WIN_BITS:0]  io_base,
  output logic                     hit,
  output logic                     is_read,
  output logic [IDX_W-1:0]         idx,
  output logic                     idx_ok
);
  localparam int OFF_W    = MEM_WIN_BITS - 2;
  localparam int IO_OFF_W = IO_WIN_BITS - 2;

  logic             mem_cmd, io_cmd, mem_hit, io_hit;
  logic [OFF_W-1:0] off;
  logic             unused_low_bits;

  assign unused_low_bits = ^addr[1:0];

  always_comb begin
    mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    io_cmd  = (cmd == CMD_IO_RD)  || (cmd == CMD_IO_WR);
    mem_hit = mem_cmd && (addr[31:MEM_WIN_BITS] == mem_base);
    io_hit  = io_cmd  && (addr[31:IO_WIN_BITS]  == io_base);
    if (mem_hit) off = addr[MEM_WIN_BITS-1:2];
    else         off = OFF_W'(addr[IO_OFF_W+1:2]);
    hit     = mem_hit || io_hit;
    is_read = !cmd[0];
    idx     = off[IDX_W-1:0];
    idx_ok  = (off < OFF_W'(NREGS));
  end
endmodule

// File: rtl/pci_csr_regbank.sv
`timescale 1ns/1ps
module pci_csr_regbank #(
  parameter int NREGS = 8,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_ok,
  output logic [31:0]      rd_data
);
  logic [31:0] bank [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) bank[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

  always_comb begin
    if (rd_ok) rd_data = bank[rd_idx];
    else       rd_data = '0;
  end
endmodule

// File: rtl/pci_csr_target.sv
`timescale 1ns/1ps
module pci_csr_target
  import pci_csr_pkg::*;
#(
  parameter int MEM_WIN_BITS = 12,
  parameter int IO_WIN_BITS  = 6,
  parameter int NREGS        = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_n,
  input  logic                     irdy_n,
  input  logic [31:0]              ad_in,
  input  logic [3:0]               cbe_n,
  input  logic [31-MEM_WIN_BITS:0] mem_base,
  input  logic [31-IO_WIN_BITS:0]  io_base,
  output logic [31:0]              ad_out,
  output logic                     ad_oe,
  output logic                     trdy_n,
  output logic                     stop_n,
  output logic                     devsel_n,
  output logic                     ctl_oe
);
  localparam int IDX_W = $clog2(NREGS);

  tgt_state_e       state;
  logic             frame_q;
  logic             rd_q, ok_q;
  logic [IDX_W-1:0] idx_q;

  logic             dec_hit, dec_rd, dec_ok;
  logic [IDX_W-1:0] dec_idx;
  logic             wr_en;
  logic [31:0]      rd_data;
  logic             addr_phase;

  pci_csr_decode #(
    .MEM_WIN_BITS(MEM_WIN_BITS), .IO_WIN_BITS(IO_WIN_BITS),
    .NREGS(NREGS), .IDX_W(IDX_W)
  ) decode_i (
    .addr(ad_in), .cmd(cbe_n), .mem_base(mem_base), .io_base(io_base),
    .hit(dec_hit), .is_read(dec_rd), .idx(dec_idx), .idx_ok(dec_ok)
  );

  assign wr_en      = (state == ST_DATA) && !irdy_n && !rd_q && ok_q;
  assign addr_phase = !frame_n && frame_q;

  pci_csr_regbank #(.NREGS(NREGS), .IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx_q), .wr_be(~cbe_n),
    .wr_data(ad_in), .rd_idx(idx_q), .rd_ok(ok_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frame_q  <= 1'b1;
      rd_q     <= 1'b0;
      ok_q     <= 1'b0;
      idx_q    <= '0;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      devsel_n <= 1'b1;
      ctl_oe   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (state)
        ST_IDLE: begin
          if (addr_phase) begin
            if (dec_hit) begin
              state  <= ST_DECODE;
              rd_q   <= dec_rd;
              ok_q   <= dec_ok;
              idx_q  <= dec_idx;
              ctl_oe <= 1'b1;
            end else begin
              state <= ST_BUSY;
            end
          end
        end
        ST_DECODE: begin
          devsel_n <= 1'b0;
          trdy_n   <= 1'b0;
          stop_n   <= 1'b0;
          if (rd_q) begin
            ad_oe  <= 1'b1;
            ad_out <= rd_data;
          end
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (!irdy_n) begin
            trdy_n <= 1'b1;
            ad_oe  <= 1'b0;
            state  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (frame_n && irdy_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            state    <= ST_TURN;
          end
        end
        ST_TURN: begin
          ctl_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_BUSY: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: STOP# accompanies every TRDY#
  assert_stop_with_trdy_R4: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !stop_n);

  // R4: a completed data phase is never followed by another
  assert_single_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && !irdy_n) |=> trdy_n);

  // R5: initiator stall freezes handshake and read data
  assert_wait_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> (!trdy_n && !stop_n && !devsel_n && $stable(ad_out)));

  // R3: claim and TRDY# arrive together, after a driven-high clock
  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (!trdy_n && $past(ctl_oe)));

  // R6: AD only driven while the control drivers are on
  assert_ad_oe_inside_R6: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> ctl_oe);

  // R2: an unclaimed transaction leaves the bus alone
  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY) |-> (!ctl_oe && devsel_n && trdy_n));

  // R7: bank writes happen only on a claimed, ready data phase
  assert_write_in_phase_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!trdy_n && !devsel_n && !ad_oe));

  // R9: drivers released one clock after the high turnaround
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |=> (!ctl_oe && devsel_n && stop_n));
endmodule

// File: tb/pci_csr_target_tb.sv
`timescale 1ns/1ps
module pci_csr_target_tb_top;
  localparam int MEM_WIN_BITS = 12;
  localparam int IO_WIN_BITS  = 6;
  localparam int NREGS        = 8;
  localparam logic [19:0] MEM_BASE = 20'hABCDE;
  localparam logic [25:0] IO_BASE  = 26'h0000C34;
  localparam logic [3:0] C_IOR = 4'b0010, C_IOW = 4'b0011;
  localparam logic [3:0] C_MR  = 4'b0110, C_MW  = 4'b0111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_out;
  logic        ad_oe, trdy_n, stop_n, devsel_n, ctl_oe;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [31:0] model [NREGS];

  always #2.5 clk = ~clk;

  pci_csr_target #(.MEM_WIN_BITS(MEM_WIN_BITS), .IO_WIN_BITS(IO_WIN_BITS), .NREGS(NREGS)) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .mem_base(MEM_BASE), .io_base(IO_BASE), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ctl_oe(ctl_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_addr(input int off);
    logic [9:0] o = 10'(off);
    return {MEM_BASE, o, 2'b00};
  endfunction

  function automatic logic [31:0] io_addr(input int off);
    logic [3:0] o = 4'(off);
    return {IO_BASE, o, 2'b00};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] wdat,
                      input logic [3:0] be, input int waits, input bit burst, input bit hit,
                      output logic [31:0] rdat);
    bit is_rd = !cmd[0];
    int w = waits;
    logic [31:0] first;
    rdat = '0;
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(posedge clk); #1;
    ad_in = is_rd ? 32'h0 : wdat; cbe_n = ~be;
    if (!hit) begin
      frame_n = 1'b1; irdy_n = 1'b0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        check(!ctl_oe && !ad_oe && devsel_n && trdy_n && stop_n, "R2 miss claimed",
              {27'b0, ctl_oe, ad_oe, devsel_n, trdy_n, stop_n}, 32'h7);
      end
      @(posedge clk); #1;
      irdy_n = 1'b1;
      idle(2);
      return;
    end
    irdy_n  = (w == 0) ? 1'b0 : 1'b1;
    frame_n = (!burst && w == 0);
    @(negedge clk);
    check(devsel_n && trdy_n, "R1 claim too early", {30'b0, devsel_n, trdy_n}, 32'h3);
    check(!ad_oe, "R6 turnaround", {31'b0, ad_oe}, 32'h0);
    @(negedge clk);
    check(!devsel_n, "R1 medium claim", {31'b0, devsel_n}, 32'h0);
    check(!trdy_n, "R3 zero wait", {31'b0, trdy_n}, 32'h0);
    check(!stop_n, "R4 stop with trdy", {31'b0, stop_n}, 32'h0);
    if (is_rd) check(ad_oe, "R6 read drive", {31'b0, ad_oe}, 32'h1);
    first = ad_out;
    while (w > 0) begin
      @(posedge clk); #1;
      w--;
      if (w == 0) begin
        irdy_n = 1'b0; frame_n = !burst;
      end
      @(negedge clk);
      check(!trdy_n && !stop_n && !devsel_n && ad_out == first, "R5 stall stability",
            ad_out, first);
    end
    rdat = ad_out;
    @(posedge clk); #1;
    frame_n = 1'b1;
    irdy_n  = burst ? 1'b0 : 1'b1;
    @(negedge clk);
    check(trdy_n, "R4 single data phase", {31'b0, trdy_n}, 32'h1);
    check(!ad_oe, "R6 release after transfer", {31'b0, ad_oe}, 32'h0);
    if (burst) begin
      @(posedge clk); #1;
      irdy_n = 1'b1;
      @(negedge clk);
      check(trdy_n, "R4 burst disconnected", {31'b0, trdy_n}, 32'h1);
    end
    @(negedge clk);
    check(devsel_n && stop_n && ctl_oe, "R9 high turnaround",
          {29'b0, devsel_n, stop_n, ctl_oe}, 32'h7);
    @(negedge clk);
    check(!ctl_oe, "R9 drivers released", {31'b0, ctl_oe}, 32'h0);
    idle(1);
  endtask

  task automatic model_wr(input int off, input logic [31:0] d, input logic [3:0] be);
    if (off < NREGS)
      for (int b = 0; b < 4; b++)
        if (be[b]) model[off][b*8 +: 8] = d[b*8 +: 8];
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] wd;
    logic [31:0] keep;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!ctl_oe && !ad_oe && devsel_n && trdy_n && stop_n, "R10 reset outputs",
          {27'b0, ctl_oe, ad_oe, devsel_n, trdy_n, stop_n}, 32'h7);
    for (int off = 0; off < NREGS; off++) begin
      xact(C_MR, mem_addr(off), 0, 4'hF, 0, 0, 1, r);
      check(r == 32'h0, "R10 register reset value", r, 32'h0);
    end
    for (int off = 0; off < NREGS + 2; off++) begin
      wd = 32'h5A000000 + 32'(off) * 32'h00010307;
      xact(C_MW, mem_addr(off), wd, 4'hF, off % 3, 0, 1, r);
      model_wr(off, wd, 4'hF);
    end
    for (int off = 0; off < 16; off++) begin
      xact(C_IOR, io_addr(off), 0, 4'hF, (off % 2) * 2, 0, 1, r);
      check(r == ((off < NREGS) ? model[off] : 32'h0), "R8 cross-window read", r,
            (off < NREGS) ? model[off] : 32'h0);
    end
    for (int be = 0; be < 16; be++) begin
      logic [3:0] b4 = 4'(be);
      wd = {4{b4, 4'h9}} ^ 32'h13579BDF;
      xact(C_IOW, io_addr(3), wd, b4, be % 3, b4[0], 1, r);
      model_wr(3, wd, b4);
      xact(C_MR, mem_addr(3), 0, 4'hF, 1, b4[1], 1, r);
      check(r == model[3], "R7 byte enables", r, model[3]);
    end
    keep = model[7];
    xact(C_MW, mem_addr(1023), 32'hDEADBEEF, 4'hF, 0, 0, 1, r);
    xact(C_IOW, io_addr(15), 32'hCAFEF00D, 4'hF, 1, 0, 1, r);
    xact(C_MR, mem_addr(7), 0, 4'hF, 0, 0, 1, r);
    check(r == keep, "R8 no alias from high offset", r, keep);
    xact(C_MR, mem_addr(1023), 0, 4'hF, 2, 0, 1, r);
    check(r == 32'h0, "R8 unimplemented reads zero", r, 32'h0);
    xact(C_MW, mem_addr(5), 32'h0BAD5EED, 4'hF, 0, 1, 1, r);
    model_wr(5, 32'h0BAD5EED, 4'hF);
    xact(C_IOR, io_addr(5), 0, 4'hF, 0, 1, 1, r);
    check(r == model[5], "R4 burst read data", r, model[5]);
    keep = model[2];
    xact(C_MW, {MEM_BASE ^ 20'h1, 10'd2, 2'b00}, 32'h11111111, 4'hF, 0, 0, 0, r);
    xact(C_IOW, mem_addr(2), 32'h22222222, 4'hF, 0, 0, 0, r);
    xact(C_MW, io_addr(2), 32'h33333333, 4'hF, 0, 0, 0, r);
    xact(C_IOW, {IO_BASE ^ 26'h1, 4'd2, 2'b00}, 32'h44444444, 4'hF, 0, 0, 0, r);
    xact(4'b1011, mem_addr(2), 32'h55555555, 4'hF, 0, 0, 0, r);
    xact(4'b1010, mem_addr(2), 0, 4'hF, 0, 0, 0, r);
    xact(4'b1100, mem_addr(2), 0, 4'hF, 0, 0, 0, r);
    xact(C_MR, mem_addr(2), 0, 4'hF, 0, 0, 1, r);
    check(r == keep, "R2 miss did not write", r, keep);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule